// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside the fetch logic of a small 8-bit processor core and chooses which interrupt, if any, the core enters at the next instruction boundary. Two kinds of sources feed it. Edge-event sources raise a sticky pending flag. Level-condition sources request service only while their condition is present. A request qualifies only when its own enable bit and the global enable are both one. The qualifying source with the lowest vector index wins.

When the core reports an instruction boundary and a request qualifies, the block asserts a take strobe for that cycle. It also drives the number of the winning source and its vector address. The address is the table base plus the source number times a parameterized spacing in words. On a take, the block clears the global enable and the flag of the source that was taken. The return handshake sets the global enable again. After that return, one instruction boundary must pass before another interrupt can be taken.

Software can set or clear the global enable with one-cycle commands, and the clear command acts within its own cycle. It can clear flags by writing ones. A select input moves the vector table from address zero to the boot base, and a static configuration input does the same for the reset vector. The reset vector is slot 0. Edge source k uses slot k+1, so edge source 0 has the highest interrupt priority. Level source j uses slot N_EDGE+j+1.

Top module: `irq_arbiter`

## Requirements
- R1: Among qualifying sources the lowest slot number wins, and `irq_id` reports that slot (edge bit k is slot k+1, level bit j is slot N_EDGE+j+1, and `src_en` bit i enables slot i+1); `irq_id` is zero when nothing is taken.
- R2: `irq_take` is high only in a cycle with `insn_boundary` high, the global enable set, and at least one source whose `src_en` bit is set and whose flag or level is present.
- R3: The cycle after a take, `gie` is 0. A `reti` pulse without a take or a disable in the same cycle makes `gie` 1 in the next cycle.
- R4: A `gie_set` pulse issued inside a handler re-opens acceptance, so an enabled request can preempt the running handler at the next allowed boundary.
- R5: An `edge_evt` bit sets its flag in the next cycle regardless of enables. The flag stays set until it is taken or cleared, and a take clears the winning edge flag. A new event in the same cycle as a clear leaves the flag set.
- R6: A `flag_wr` cycle clears each flag whose `flag_wdata` bit is one. Bits written as zero leave their flags unchanged.
- R7: Several flags pending when the global enable turns on are taken one per entry, highest priority first.
- R8: Level sources have no memory: a level condition that drops before its enable is set never causes a take.
- R9: After a `reti`, the first `insn_boundary` cannot be used for a take. Later boundaries can.
- R10: `gie_clr` blocks a take in its own cycle and leaves `gie` at 0 in the next cycle.
- R11: `irq_vec` equals the base plus the slot number times SPACING. The base is 0 when `ivt_sel` is 0 and BOOT_BASE (default 12'hE00, spacing 2) when it is 1.
- R12: `reset_vec` is 0 when `boot_rst_sel` is 0 and BOOT_BASE when it is 1.
- R13: After reset, `gie` is 0, all flags are 0, and there is no take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_rst_sel | input | 1 | Static: place the reset vector at the boot base |
| ivt_sel | input | 1 | Place the interrupt table at the boot base |
| edge_evt | input | N_EDGE | One-cycle event pulses for the flagged sources |
| lvl_req | input | N_LEVEL | Present conditions for the level sources |
| src_en | input | N_EDGE+N_LEVEL | Per-slot enables, bit i for slot i+1 |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable, effective at once |
| flag_wr | input | 1 | Write strobe for clearing flags |
| flag_wdata | input | N_EDGE | Ones select the flags to clear |
| insn_boundary | input | 1 | The core is between instructions |
| reti | input | 1 | Return-from-handler handshake |
| irq_take | output | 1 | The interrupt is accepted in this cycle |
| irq_id | output | clog2(N_EDGE+N_LEVEL+1) | Slot taken, 0 when none |
| irq_vec | output | ADDR_W | Vector address of the winning slot |
| reset_vec | output | ADDR_W | Reset vector address |
| gie | output | 1 | Global enable state |
| flags | output | N_EDGE | Pending edge flags |

## Verification
A wrong global enable or a wrong return-gap state shows up at the next instruction boundary. At that boundary `irq_take` either fires when it must not or stays low beside a visible pending request. The bench compares the take against a reference model on every cycle, so such an error is reported within one cycle of the first boundary it affects. A flag that was lost, left over or cleared wrongly differs on the `flags` output one cycle after the event or write. A wrong arbitration result appears in the same cycle as the take, as a wrong `irq_id` or `irq_vec`.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_EDGE = 4,
  parameter int N_LEVEL = 2,
  parameter int ADDR_W = 12,
  parameter int SPACING = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 12'hE00,
  localparam int N_SRC = N_EDGE + N_LEVEL,
  localparam int ID_W = $clog2(N_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_rst_sel,
  input  logic              ivt_sel,
  input  logic [N_EDGE-1:0] edge_evt,
  input  logic [N_LEVEL-1:0] lvl_req,
  input  logic [N_SRC-1:0]  src_en,
  input  logic              gie_set,
  input  logic              gie_clr,
  input  logic              flag_wr,
  input  logic [N_EDGE-1:0] flag_wdata,
  input  logic              insn_boundary,
  input  logic              reti,
  output logic              irq_take,
  output logic [ID_W-1:0]   irq_id,
  output logic [ADDR_W-1:0] irq_vec,
  output logic [ADDR_W-1:0] reset_vec,
  output logic              gie,
  output logic [N_EDGE-1:0] flags
);

  logic              gie_q, hold_q;
  logic [N_EDGE-1:0] flag_q;
  logic [ID_W-1:0]   win;
  logic [N_EDGE-1:0] take_clr;

  wire [N_SRC-1:0] pend = {lvl_req, flag_q} & src_en;

  always_comb begin
    win = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (pend[i]) win = ID_W'(i + 1);
  end

  assign irq_take  = insn_boundary & gie_q & ~gie_clr & ~hold_q & (|pend);
  assign irq_id    = irq_take ? win : '0;
  assign irq_vec   = (ivt_sel ? BOOT_BASE : '0) + ADDR_W'(int'(win) * SPACING);
  assign reset_vec = boot_rst_sel ? BOOT_BASE : '0;
  assign gie       = gie_q;
  assign flags     = flag_q;

  for (genvar k = 0; k < N_EDGE; k++) begin : g_clr
    assign take_clr[k] = irq_take && (win == ID_W'(k + 1));
  end

  wire [N_EDGE-1:0] wr_clr = flag_wr ? flag_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
      flag_q <= '0;
    end else begin
      flag_q <= (flag_q & ~wr_clr & ~take_clr) | edge_evt;
      if (gie_clr || irq_take)  gie_q <= 1'b0;
      else if (gie_set || reti) gie_q <= 1'b1;
      if (reti)               hold_q <= 1'b1;
      else if (insn_boundary) hold_q <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int N_EDGE = 4,
  parameter int N_LEVEL = 2,
  parameter int ID_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_EDGE-1:0] edge_evt,
  input logic              gie_set,
  input logic              gie_clr,
  input logic              flag_wr,
  input logic [N_EDGE-1:0] flag_wdata,
  input logic              insn_boundary,
  input logic              reti,
  input logic              irq_take,
  input logic [ID_W-1:0]   irq_id,
  input logic              gie,
  input logic [N_EDGE-1:0] flags
);

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (insn_boundary && gie)); // R2

  AST_TAKE_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_id != '0)); // R1

  AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !gie); // R3

  AST_RETI_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_take && !gie_clr) |=> gie); // R3

  AST_CLR_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |-> (!irq_take ##1 !gie)); // R10

  AST_RETURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> !irq_take); // R9

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_evt) |=> ((flags & $past(edge_evt)) == $past(edge_evt))); // R5

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && edge_evt == '0) |=> ((flags & $past(flag_wdata)) == '0)); // R6

  AST_SET_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_set && !gie_clr && !irq_take) |=> gie); // R4

endmodule

bind irq_arbiter irq_arbiter_chk #(.N_EDGE(N_EDGE), .N_LEVEL(N_LEVEL), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .gie_set(gie_set), .gie_clr(gie_clr),
  .flag_wr(flag_wr), .flag_wdata(flag_wdata), .insn_boundary(insn_boundary), .reti(reti),
  .irq_take(irq_take), .irq_id(irq_id), .gie(gie), .flags(flags)
);

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
  localparam int NE = 4, NL = 2, NS = 6;
  localparam logic [11:0] BB = 12'hE00;

  logic clk = 0, rst_n = 0;
  logic boot_rst_sel = 0, ivt_sel = 0;
  logic [NE-1:0] edge_evt = '0, flag_wdata = '0;
  logic [NL-1:0] lvl_req = '0;
  logic [NS-1:0] src_en = '0;
  logic gie_set = 0, gie_clr = 0, flag_wr = 0, insn_boundary = 0, reti = 0;
  logic irq_take, gie;
  logic [2:0] irq_id;
  logic [11:0] irq_vec, reset_vec;
  logic [NE-1:0] flags;

  int checks = 0, errors = 0;
  logic m_gie = 0, m_hold = 0;
  logic [NE-1:0] m_flags = '0;

  always #2.5 clk = ~clk;

  irq_arbiter uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int winner(logic [NS-1:0] p);
    for (int i = 0; i < NS; i++) if (p[i]) return i + 1;
    return 0;
  endfunction

  function automatic logic exp_take();
    logic [NS-1:0] p = {lvl_req, m_flags} & src_en;
    return insn_boundary && m_gie && !gie_clr && !m_hold && (p != '0);
  endfunction

  task automatic settle();
    logic [NS-1:0] p;
    int w;
    #1;
    p = {lvl_req, m_flags} & src_en;
    w = winner(p);
    chk("R2 take", 32'(irq_take), 32'(exp_take()));
    if (exp_take()) begin
      chk("R1 id", 32'(irq_id), 32'(w));
      chk("R11 vec", 32'(irq_vec), 32'((ivt_sel ? BB : 12'h0) + 12'(w * 2)));
    end
    chk("R3 gie", 32'(gie), 32'(m_gie));
    chk("R5 flags", 32'(flags), 32'(m_flags));
  endtask

  task automatic adv();
    logic t;
    logic [NE-1:0] tc;
    int w;
    @(posedge clk);
    t = exp_take();
    w = winner({lvl_req, m_flags} & src_en);
    tc = '0;
    if (t && w >= 1 && w <= NE) tc[w-1] = 1'b1;
    m_flags = (m_flags & ~(flag_wr ? flag_wdata : '0) & ~tc) | edge_evt;
    if (gie_clr || t) m_gie = 0; else if (gie_set || reti) m_gie = 1;
    if (reti) m_hold = 1; else if (insn_boundary) m_hold = 0;
    @(negedge clk);
    edge_evt = '0; gie_set = 0; gie_clr = 0; flag_wr = 0; reti = 0;
  endtask

  task automatic cyc();
    settle();
    adv();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk("R13 gie", 32'(gie), 0);
    chk("R13 flags", 32'(flags), 0);
    chk("R13 take", 32'(irq_take), 0);
    chk("R12 reset vec low", 32'(reset_vec), 0);
    boot_rst_sel = 1; #1;
    chk("R12 reset vec boot", 32'(reset_vec), 32'(BB));
    boot_rst_sel = 0;
    @(negedge clk); rst_n = 1;
    src_en = '1; insn_boundary = 1;

    edge_evt = 4'b1010; cyc();
    settle(); chk("R5 latched while off", 32'(flags), 32'h0A);
    gie_set = 1; adv();
    settle();
    chk("R7 first slot", 32'(irq_id), 2);
    chk("R11 vec 4", 32'(irq_vec), 4);
    adv();
    insn_boundary = 0; reti = 1; cyc();
    insn_boundary = 1; settle();
    chk("R9 gap boundary", 32'(irq_take), 0);
    adv(); settle();
    chk("R7 second slot", 32'(irq_id), 4);
    adv();
    insn_boundary = 0; reti = 1; cyc();
    insn_boundary = 1; edge_evt = 4'b0001; cyc();
    gie_clr = 1; settle();
    chk("R10 same-cycle block", 32'(irq_take), 0);
    adv(); settle();
    chk("R10 gie off", 32'(gie), 0);
    flag_wr = 1; flag_wdata = 4'b0010; adv(); settle();
    chk("R6 zero write kept", 32'(flags), 1);
    flag_wr = 1; flag_wdata = 4'b0001; adv(); settle();
    chk("R6 one write clears", 32'(flags), 0);
    src_en = 6'b001111; lvl_req = 2'b01; gie_set = 1; cyc();
    cyc();
    lvl_req = 0; cyc();
    src_en = '1; settle();
    chk("R8 vanished level", 32'(irq_take), 0);
    adv();
    ivt_sel = 1; lvl_req = 2'b01; settle();
    chk("R11 boot vec", 32'(irq_vec), 32'(BB + 12'd10));
    chk("R8 level taken", 32'(irq_id), 5);
    adv();
    gie_set = 1; cyc(); settle();
    chk("R4 nested take", 32'(irq_take), 1);
    adv();
    lvl_req = 0; reti = 1; cyc();

    for (int n = 0; n < 4000; n++) begin
      edge_evt = ($urandom % 6 == 0) ? 4'($urandom) : '0;
      if ($urandom % 10 == 0) lvl_req = 2'($urandom);
      if ($urandom % 40 == 0) src_en = 6'($urandom);
      if ($urandom % 200 == 0) ivt_sel = ~ivt_sel;
      gie_set = ($urandom % 16 == 0);
      gie_clr = ($urandom % 30 == 0);
      flag_wr = ($urandom % 14 == 0);
      flag_wdata = 4'($urandom);
      insn_boundary = $urandom % 2 == 0;
      reti = ($urandom % 9 == 0);
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule